// File: doc/BRIEF.md
# SPI Slave Byte Engine with Sticky Status Flags

This block is the receive and transmit datapath of a byte-wide SPI slave that lives entirely in the system clock domain. The serial clock, data-in and select pins from an external master are oversampled through synchronizer flops. Edges of the serial clock are detected as single-cycle events and drive a bit counter and two shift registers. Only clock polarity 0 / phase 0 is handled: input bits are captured on the rising serial clock edge, output bits advance on the falling edge, and both directions run most significant bit first. The serial clock may run at no more than a quarter of the system clock rate.

Software sees a data-write strobe, a data-read strobe with the receive buffer on a read bus, a control write, and a per-flag clear vector. Outgoing bytes pass through a holding register before they reach the shift register, which lets the next byte be queued while one is in flight. Incoming bytes land in a single receive buffer. Four sticky flags (byte done, write collision, receive overrun, mode fault) are ORed into one interrupt line. A mode-fault input exists only to drop the enable bits and record the event.

Top module: `spi_slave_flags`

## Requirements
- R1: After eight rising serial clock edges while active, the byte captured most significant bit first appears on `dat_rdata_o` and flag bit 0 (byte done) is set.
- R2: `miso_o` presents the most significant bit of the loaded byte before the first rising edge, and it advances to the next bit after each falling edge that follows a rising edge of the same byte.
- R3: A data write into an empty holding register moves to an empty shift register on the next cycle. A byte written while the shift register is loaded waits in the holding register and is loaded into the shift register when the byte in flight completes, so it is sent in the next transfer.
- R4: A data write while the holding register is still full sets flag bit 1 (write collision) and is discarded. The holding register keeps its earlier byte.
- R5: When a byte completes while the receive buffer holds an unread byte, flag bit 2 (overrun) is set, the new byte is dropped and `dat_rdata_o` keeps the old byte. A `dat_rd_i` pulse marks the buffer read.
- R6: With mode field 2'b01 (four-wire), the slave ignores the serial clock and holds `miso_oe_o` low while the select pin is high. Raising and then lowering the select restarts the bit count at zero.
- R7: With mode field 2'b00 (three-wire), the select pin has no effect. The bit count restarts only when the enable bit is cleared and then set again.
- R8: Every flag stays set until software writes a 1 to its bit in `flag_clr_i`. `irq_o` is high whenever any flag is set. A set event in the same cycle as a clear wins.
- R9: A pulse on `modf_i` clears the enable and master-enable bits and sets flag bit 3 (mode fault).
- R10: After reset the flags are 0, `irq_o` and `miso_oe_o` are low, and `ctl_o` reads 4'b0100.
- R11: The control field layout is bit 0 enable, bit 1 master enable (held only), bits 3:2 mode. `ctl_wr_i` loads all four bits, and `ctl_o` returns them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock from the master |
| mosi_i | input | 1 | Serial data from the master |
| nss_i | input | 1 | Active-low slave select |
| miso_o | output | 1 | Serial data to the master |
| miso_oe_o | output | 1 | Output enable for the serial data pad |
| ctl_wr_i | input | 1 | Control write strobe |
| ctl_wdata_i | input | 4 | Control write value |
| ctl_o | output | 4 | Control field readback |
| dat_wr_i | input | 1 | Transmit byte write strobe |
| dat_wdata_i | input | DW | Transmit byte |
| dat_rd_i | input | 1 | Receive buffer read strobe |
| dat_rdata_o | output | DW | Receive buffer contents |
| flag_clr_i | input | 4 | Write-one-to-clear per flag |
| modf_i | input | 1 | Mode-fault event |
| flags_o | output | 4 | Sticky flags: done, collision, overrun, mode fault |
| irq_o | output | 1 | OR of all flags |

## Verification
A pin change reaches the edge detector after two synchronizer edges. The shift and count action it causes lands on the third system clock edge. The byte-done pulse is registered on that same edge, so the flags and the receive buffer change one edge later, and a queued byte reaches the shift register two edges after that. Register strobes act on the next edge, and the flags they set are visible from that edge on. The bench holds every serial clock phase for four system clocks and samples only on falling system clock edges. Every result it checks is therefore already settled by at least one cycle.

// File: rtl/spi_sf_pkg.sv
package spi_sf_pkg;

  localparam int NFLAG   = 4;
  localparam int FL_DONE = 0;
  localparam int FL_WCOL = 1;
  localparam int FL_OVR  = 2;
  localparam int FL_MODF = 3;

  localparam logic [1:0] MODE_3W = 2'b00;
  localparam logic [1:0] MODE_4W = 2'b01;

  typedef struct packed {
    logic [1:0] mode;
    logic       mst;
    logic       en;
  } ctl_t;

  localparam ctl_t CTL_RST = '{mode: MODE_4W, mst: 1'b0, en: 1'b0};

endpackage

// File: rtl/spi_sf_sync.sv
module spi_sf_sync #(
  parameter int         W       = 3,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic [W-1:0] prev
);

  localparam int DEPTH = STAGES + 1;

  logic [DEPTH-1:0][W-1:0] chain_q;
  logic [DEPTH-1:0][W-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[DEPTH-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {DEPTH{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign q    = chain_q[STAGES-1];
  assign prev = chain_q[STAGES];

endmodule

// File: rtl/spi_sf_shifter.sv
module spi_sf_shifter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic          cnt_clr,
  input  logic          sck_rise,
  input  logic          sck_fall,
  input  logic          mosi,
  input  logic          tx_load,
  input  logic [DW-1:0] tx_data,
  output logic          miso,
  output logic          done_p,
  output logic [DW-1:0] rx_byte,
  output logic          tx_loaded
);

  localparam int          CW   = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] rx_q, rx_d;
  logic [DW-1:0] tx_q, tx_d;
  logic          ld_q, ld_d;
  logic          done_q, done_d;

  always_comb begin
    cnt_d  = cnt_q;
    rx_d   = rx_q;
    tx_d   = tx_q;
    ld_d   = ld_q;
    done_d = 1'b0;
    if (cnt_clr) begin
      cnt_d = '0;
    end else if (active && sck_rise) begin
      rx_d = {rx_q[DW-2:0], mosi};
      if (cnt_q == LAST) begin
        cnt_d  = '0;
        done_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else if (active && sck_fall && (cnt_q != '0)) begin
      tx_d = {tx_q[DW-2:0], 1'b0};
    end
    if (done_q) ld_d = 1'b0;
    if (tx_load) begin
      tx_d = tx_data;
      ld_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      rx_q   <= '0;
      tx_q   <= '0;
      ld_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      rx_q   <= rx_d;
      tx_q   <= tx_d;
      ld_q   <= ld_d;
      done_q <= done_d;
    end
  end

  assign miso      = tx_q[DW-1];
  assign done_p    = done_q;
  assign rx_byte   = rx_q;
  assign tx_loaded = ld_q;

endmodule

// File: rtl/spi_sf_regs.sv
module spi_sf_regs
  import spi_sf_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  ctl_t             ctl_wdata,
  input  logic [NFLAG-1:0] flag_clr,
  input  logic             dat_wr,
  input  logic [DW-1:0]    dat_wdata,
  input  logic             dat_rd,
  input  logic             modf,
  input  logic             done_p,
  input  logic [DW-1:0]    rx_byte,
  input  logic             tx_loaded,
  output ctl_t             ctl,
  output logic [NFLAG-1:0] flags,
  output logic [DW-1:0]    rdata,
  output logic             tx_load,
  output logic [DW-1:0]    tx_data,
  output logic             txbuf_full,
  output logic             rx_full
);

  ctl_t             ctl_q, ctl_d;
  logic [DW-1:0]    txb_q, txb_d;
  logic             txf_q, txf_d;
  logic [DW-1:0]    rxb_q, rxb_d;
  logic             rxf_q, rxf_d;
  logic [NFLAG-1:0] flg_q, flg_d, flg_set;

  always_comb begin
    ctl_d = ctl_q;
    if (ctl_wr) ctl_d = ctl_wdata;
    if (modf) begin
      ctl_d.en  = 1'b0;
      ctl_d.mst = 1'b0;
    end
  end

  assign tx_load = txf_q && !tx_loaded;

  always_comb begin
    txb_d = txb_q;
    txf_d = txf_q;
    if (tx_load) txf_d = 1'b0;
    if (dat_wr && !txf_q) begin
      txb_d = dat_wdata;
      txf_d = 1'b1;
    end
  end

  always_comb begin
    rxb_d = rxb_q;
    rxf_d = rxf_q;
    if (dat_rd) rxf_d = 1'b0;
    if (done_p && !rxf_q) begin
      rxb_d = rx_byte;
      rxf_d = 1'b1;
    end
  end

  always_comb begin
    flg_set          = '0;
    flg_set[FL_DONE] = done_p;
    flg_set[FL_WCOL] = dat_wr && txf_q;
    flg_set[FL_OVR]  = done_p && rxf_q;
    flg_set[FL_MODF] = modf;
  end

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    assign flg_d[g] = flg_set[g] | (flg_q[g] & ~flag_clr[g]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= CTL_RST;
      txb_q <= '0;
      txf_q <= 1'b0;
      rxb_q <= '0;
      rxf_q <= 1'b0;
      flg_q <= '0;
    end else begin
      ctl_q <= ctl_d;
      txb_q <= txb_d;
      txf_q <= txf_d;
      rxb_q <= rxb_d;
      rxf_q <= rxf_d;
      flg_q <= flg_d;
    end
  end

  assign ctl        = ctl_q;
  assign flags      = flg_q;
  assign rdata      = rxb_q;
  assign tx_data    = txb_q;
  assign txbuf_full = txf_q;
  assign rx_full    = rxf_q;

endmodule

// File: rtl/spi_slave_flags.sv
module spi_slave_flags
  import spi_sf_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sck_i,
  input  logic          mosi_i,
  input  logic          nss_i,
  output logic          miso_o,
  output logic          miso_oe_o,
  input  logic          ctl_wr_i,
  input  logic [3:0]    ctl_wdata_i,
  output logic [3:0]    ctl_o,
  input  logic          dat_wr_i,
  input  logic [DW-1:0] dat_wdata_i,
  input  logic          dat_rd_i,
  output logic [DW-1:0] dat_rdata_o,
  input  logic [3:0]    flag_clr_i,
  input  logic          modf_i,
  output logic [3:0]    flags_o,
  output logic          irq_o
);

  localparam int PIN_SCK  = 0;
  localparam int PIN_MOSI = 1;
  localparam int PIN_NSS  = 2;
  localparam int NPIN     = 3;
  localparam logic [NPIN-1:0] PIN_IDLE = 3'b100;

  logic [NPIN-1:0] pin_q, pin_prev;
  logic            unused_mosi_prev;
  logic            sck_rise, sck_fall, nss_fall, nss_high, four_wire;
  logic            active, cnt_clr, done_p, tx_load, tx_loaded;
  logic            txbuf_full, rx_full, miso;
  logic [DW-1:0]   rx_byte, tx_data;
  ctl_t            ctl;

  spi_sf_sync #(
    .W      (NPIN),
    .STAGES (SYNC_STAGES),
    .RST_VAL(PIN_IDLE)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({nss_i, mosi_i, sck_i}),
    .q    (pin_q),
    .prev (pin_prev)
  );

  assign unused_mosi_prev = pin_prev[PIN_MOSI];
  assign sck_rise  =  pin_q[PIN_SCK] & ~pin_prev[PIN_SCK];
  assign sck_fall  = ~pin_q[PIN_SCK] &  pin_prev[PIN_SCK];
  assign nss_fall  = ~pin_q[PIN_NSS] &  pin_prev[PIN_NSS];
  assign nss_high  =  pin_q[PIN_NSS];
  assign four_wire = (ctl.mode == MODE_4W);
  assign active    = ctl.en && !(four_wire && nss_high);
  assign cnt_clr   = !ctl.en || (four_wire && (nss_high || nss_fall));

  spi_sf_shifter #(.DW(DW)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (active),
    .cnt_clr  (cnt_clr),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .mosi     (pin_q[PIN_MOSI]),
    .tx_load  (tx_load),
    .tx_data  (tx_data),
    .miso     (miso),
    .done_p   (done_p),
    .rx_byte  (rx_byte),
    .tx_loaded(tx_loaded)
  );

  spi_sf_regs #(.DW(DW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_wr    (ctl_wr_i),
    .ctl_wdata (ctl_t'(ctl_wdata_i)),
    .flag_clr  (flag_clr_i),
    .dat_wr    (dat_wr_i),
    .dat_wdata (dat_wdata_i),
    .dat_rd    (dat_rd_i),
    .modf      (modf_i),
    .done_p    (done_p),
    .rx_byte   (rx_byte),
    .tx_loaded (tx_loaded),
    .ctl       (ctl),
    .flags     (flags_o),
    .rdata     (dat_rdata_o),
    .tx_load   (tx_load),
    .tx_data   (tx_data),
    .txbuf_full(txbuf_full),
    .rx_full   (rx_full)
  );

  assign ctl_o     = ctl;
  assign miso_o    = miso;
  assign miso_oe_o = active;
  assign irq_o     = |flags_o;

endmodule

// File: rtl/spi_sf_checker.sv
module spi_sf_checker #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [3:0]    ctl_o,
  input logic [3:0]    flags_o,
  input logic [3:0]    flag_clr_i,
  input logic          modf_i,
  input logic          miso_oe_o,
  input logic          dat_wr_i,
  input logic          dat_rd_i,
  input logic [DW-1:0] dat_rdata_o,
  input logic          txbuf_full,
  input logic          rx_full,
  input logic          done_p
);

  p_done_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done_p |=> flags_o[0]);

  p_collide_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr_i && txbuf_full) |=> flags_o[1]);

  p_overrun_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_p && rx_full && !dat_rd_i) |=> (flags_o[2] && $stable(dat_rdata_o)));

  p_off_no_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_o[0] |-> !miso_oe_o);

  p_modf_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    modf_i |=> (ctl_o[1:0] == 2'b00 && flags_o[3]));

  for (genvar g = 0; g < 4; g++) begin : g_sticky
    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_o[g] && !flag_clr_i[g]) |=> flags_o[g]);
  end

endmodule

bind spi_slave_flags spi_sf_checker #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ctl_o      (ctl_o),
  .flags_o    (flags_o),
  .flag_clr_i (flag_clr_i),
  .modf_i     (modf_i),
  .miso_oe_o  (miso_oe_o),
  .dat_wr_i   (dat_wr_i),
  .dat_rd_i   (dat_rd_i),
  .dat_rdata_o(dat_rdata_o),
  .txbuf_full (txbuf_full),
  .rx_full    (rx_full),
  .done_p     (done_p)
);

// File: tb/test_spi_slave_flags.sv
module test_spi_slave_flags;

  localparam int CLK_PERIOD = 10;
  localparam int DW         = 8;

  logic          clk, rst_n;
  logic          sck, mosi, nss;
  logic          miso_o, miso_oe_o;
  logic          ctl_wr;
  logic [3:0]    ctl_wdata, ctl_o;
  logic          dat_wr, dat_rd;
  logic [DW-1:0] dat_wdata, dat_rdata_o;
  logic [3:0]    flag_clr, flags_o;
  logic          modf, irq_o;

  int n_chk  = 0;
  int n_fail = 0;

  spi_slave_flags #(.DW(DW)) i_spi_slave_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .sck_i      (sck),
    .mosi_i     (mosi),
    .nss_i      (nss),
    .miso_o     (miso_o),
    .miso_oe_o  (miso_oe_o),
    .ctl_wr_i   (ctl_wr),
    .ctl_wdata_i(ctl_wdata),
    .ctl_o      (ctl_o),
    .dat_wr_i   (dat_wr),
    .dat_wdata_i(dat_wdata),
    .dat_rd_i   (dat_rd),
    .dat_rdata_o(dat_rdata_o),
    .flag_clr_i (flag_clr),
    .modf_i     (modf),
    .flags_o    (flags_o),
    .irq_o      (irq_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ctl_write(input logic [3:0] v);
    ctl_wr = 1'b1; ctl_wdata = v; cyc(1); ctl_wr = 1'b0;
  endtask

  task automatic dat_write(input logic [DW-1:0] b);
    dat_wr = 1'b1; dat_wdata = b; cyc(1); dat_wr = 1'b0;
  endtask

  task automatic dat_read();
    dat_rd = 1'b1; cyc(1); dat_rd = 1'b0;
  endtask

  task automatic clr_flags(input logic [3:0] m);
    flag_clr = m; cyc(1); flag_clr = 4'h0;
  endtask

  task automatic sck_bit(input logic b, output logic so);
    so = miso_o; mosi = b; cyc(2);
    sck = 1'b1; cyc(4);
    sck = 1'b0; cyc(4);
  endtask

  task automatic xfer(input logic [DW-1:0] tx, output logic [DW-1:0] rx);
    logic so;
    for (int i = DW-1; i >= 0; i--) begin
      sck_bit(tx[i], so);
      rx[i] = so;
    end
    cyc(2);
  endtask

  task automatic t_reset();
    chk("R10 flags", 32'(flags_o), 32'h0);
    chk("R10 irq", 32'(irq_o), 32'h0);
    chk("R10 oe", 32'(miso_oe_o), 32'h0);
    chk("R10 R11 ctl", 32'(ctl_o), 32'h4);
  endtask

  task automatic t_basic();
    logic [DW-1:0] got;
    ctl_write(4'b0101);
    chk("R11 ctl readback", 32'(ctl_o), 32'h5);
    chk("R6 oe while nss high", 32'(miso_oe_o), 32'h0);
    dat_write(8'hA5); cyc(2);
    nss = 1'b0; cyc(4);
    chk("R6 oe selected", 32'(miso_oe_o), 32'h1);
    xfer(8'h3C, got);
    chk("R2 miso byte", 32'(got), 32'hA5);
    chk("R1 rx byte", 32'(dat_rdata_o), 32'h3C);
    chk("R1 done flag", 32'(flags_o), 32'h1);
    chk("R8 irq", 32'(irq_o), 32'h1);
    cyc(10);
    chk("R8 sticky", 32'(flags_o[0]), 32'h1);
    dat_read(); clr_flags(4'hF);
    chk("R8 cleared", 32'(flags_o), 32'h0);
    chk("R8 irq low", 32'(irq_o), 32'h0);
  endtask

  task automatic t_double();
    logic [DW-1:0] got;
    dat_write(8'h11); cyc(2);
    dat_write(8'h22);
    dat_write(8'h33);
    chk("R4 collision flag", 32'(flags_o[1]), 32'h1);
    xfer(8'h01, got);
    chk("R3 first byte", 32'(got), 32'h11);
    dat_read();
    xfer(8'h02, got);
    chk("R3 R4 queued byte kept", 32'(got), 32'h22);
    dat_read(); clr_flags(4'hF);
  endtask

  task automatic t_overrun();
    logic [DW-1:0] got;
    xfer(8'h5A, got);
    chk("R5 no overrun yet", 32'(flags_o[2]), 32'h0);
    xfer(8'hC3, got);
    chk("R5 overrun flag", 32'(flags_o[2]), 32'h1);
    chk("R5 old byte kept", 32'(dat_rdata_o), 32'h5A);
    dat_read(); clr_flags(4'hF);
  endtask

  task automatic t_nss();
    logic [DW-1:0] got;
    logic so;
    nss = 1'b1; cyc(4);
    chk("R6 oe deselected", 32'(miso_oe_o), 32'h0);
    xfer(8'hFF, got);
    chk("R6 ignored while high", 32'(flags_o[0]), 32'h0);
    chk("R6 rx unchanged", 32'(dat_rdata_o), 32'h5A);
    nss = 1'b0; cyc(4);
    for (int i = 0; i < 3; i++) sck_bit(1'b1, so);
    nss = 1'b1; cyc(4); nss = 1'b0; cyc(4);
    xfer(8'h96, got);
    chk("R6 count restarted", 32'(dat_rdata_o), 32'h96);
    chk("R6 done", 32'(flags_o[0]), 32'h1);
    dat_read(); clr_flags(4'hF);
    nss = 1'b1; cyc(4);
  endtask

  task automatic t_3wire();
    logic [DW-1:0] got;
    logic so;
    ctl_write(4'b0001);
    chk("R7 oe with nss high", 32'(miso_oe_o), 32'h1);
    xfer(8'h71, got);
    chk("R7 byte", 32'(dat_rdata_o), 32'h71);
    dat_read(); clr_flags(4'hF);
    for (int i = 0; i < 3; i++) sck_bit(1'b0, so);
    nss = 1'b0; cyc(4); nss = 1'b1; cyc(4);
    sck_bit(1'b1, so); sck_bit(1'b0, so); sck_bit(1'b1, so);
    sck_bit(1'b1, so); sck_bit(1'b0, so); cyc(2);
    chk("R7 nss no reset", 32'(dat_rdata_o), 32'h16);
    dat_read(); clr_flags(4'hF);
    for (int i = 0; i < 3; i++) sck_bit(1'b0, so);
    ctl_write(4'b0000); ctl_write(4'b0001);
    xfer(8'hE8, got);
    chk("R7 enable toggle resets", 32'(dat_rdata_o), 32'hE8);
    dat_read(); clr_flags(4'hF);
  endtask

  task automatic t_modf();
    ctl_write(4'b0111);
    modf = 1'b1; cyc(1); modf = 1'b0;
    chk("R9 ctl dropped", 32'(ctl_o), 32'h4);
    chk("R9 modf flag", 32'(flags_o), 32'h8);
    chk("R9 irq", 32'(irq_o), 32'h1);
    chk("R9 oe off", 32'(miso_oe_o), 32'h0);
    flag_clr = 4'h8; modf = 1'b1; cyc(1); flag_clr = 4'h0; modf = 1'b0;
    chk("R8 set wins over clear", 32'(flags_o[3]), 32'h1);
    clr_flags(4'h8);
    chk("R8 modf cleared", 32'(irq_o), 32'h0);
  endtask

  initial begin
    rst_n = 1'b0; sck = 1'b0; mosi = 1'b0; nss = 1'b1;
    ctl_wr = 1'b0; ctl_wdata = 4'h0; dat_wr = 1'b0; dat_wdata = '0;
    dat_rd = 1'b0; flag_clr = 4'h0; modf = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    t_reset();
    t_basic();
    t_double();
    t_overrun();
    t_nss();
    t_3wire();
    t_modf();
    cyc(4);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule